// File: doc/BRIEF.md
# Square-Wave Interval Timer

This block divides an external, asynchronous timer input into a square wave or a train of pulses. The input is brought into the system clock domain and only its rising edges are counted. Software stages a 14-bit count length and a two-bit output mode through two byte-wide write ports, then controls the timer through a two-bit command code. The counter moves down by two on each counted edge and passes through its range twice per output period: once for the high half and once for the low half. An odd length therefore gives a high half one count longer than the low half.

Staged settings do nothing on their own. A START command copies them into the running timer. If the timer is idle this happens at once. If it is running, the copy is deferred to the end of the current period, so the waveform never breaks mid-period. A one-clock terminal-count strobe marks the end of every period, so that a status flag outside the block can latch it. Two readback bytes expose the live counter and the staged mode bits. Reset halts the timer but leaves the staged length and mode as they were.

Top module: `sq_interval_timer`

## Requirements
- R1: After reset, and until a START command, `tmr_out` is 1, `tc_pulse` stays 0 and rising edges on `tmr_in` have no effect on either output.
- R2: A write with `len_lo_we` stages length bits 7:0 from `wr_data`. A write with `len_hi_we` stages length bits 13:8 from `wr_data[5:0]` and the mode from `wr_data[7:6]`. The modes are 00 single square wave, 01 repeating square wave, 10 single pulse and 11 repeating pulses.
- R3: Command codes on `cmd` with `cmd_we` are 00 no operation, 01 stop now, 10 stop at terminal count and 11 start. A START while idle makes the timer run from the next clock, and it counts from the next rising edge of `tmr_in`.
- R4: In the square modes with length L, `tmr_out` is 1 until edge ceil(L/2) of the period and 0 from that edge until edge L.
- R5: In the pulse modes, `tmr_out` is 0 only between edge L-1 and edge L of each period, and 1 at all other times.
- R6: `tc_pulse` is 1 for exactly one clock after edge L of each period. The single modes go idle after the first period. The repeating modes start a new period with the same settings.
- R7: Command 01 halts a running timer at once: `tmr_out` returns to 1 and no later terminal count occurs. While idle the command has no effect.
- R8: Command 10 lets the current period finish, with its terminal count, and then leaves the timer idle. While idle the command has no effect.
- R9: Staging a new length or mode while the timer runs does not change the waveform. A START while running applies the staged values from the next period on.
- R10: `rd_lo` shows counter bits 7:0. `rd_hi` shows the staged mode in bits 7:6 and counter bits 13:8 below them. A period begins with the counter at L rounded up to even, and the counter falls by 2 on each edge.
- R11: Only rising edges of `tmr_in` count. A level held high for many clocks counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_in | input | 1 | Asynchronous timer input, rising edges counted |
| len_lo_we | input | 1 | Stage low byte of count length |
| len_hi_we | input | 1 | Stage high length bits and mode |
| wr_data | input | 8 | Write data byte |
| cmd_we | input | 1 | Command strobe |
| cmd | input | 2 | Command code |
| tmr_out | output | 1 | Square wave or pulse output |
| tc_pulse | output | 1 | One-clock terminal-count strobe |
| rd_lo | output | 8 | Counter bits 7:0 |
| rd_hi | output | 8 | Staged mode and counter bits 13:8 |

## Verification
The hardest state to reach is a deferred change: a START issued partway through a running period, which must leave the rest of that period untouched and take effect only at the next boundary. The bench gets there by staging a new length while a repeating square wave is running and letting one full period pass, which shows the staged values are not yet in use. It then issues START after the first edge of a period and checks the output edge by edge, first against the old length to its end and then against the new length. Stop-at-terminal-count is reached in the same way, in the middle of a repeating pulse period.

// File: rtl/sit_pkg.sv
package sit_pkg;
  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_HALT    = 2'b01,
    CMD_HALT_TC = 2'b10,
    CMD_GO      = 2'b11
  } sit_cmd_e;

  // mode bit 0: repeat after terminal count, mode bit 1: pulse output
  localparam int MODE_REPEAT_BIT = 0;
  localparam int MODE_PULSE_BIT  = 1;
endpackage

// File: rtl/sit_edge_sync.sv
module sit_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  assert_rise_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/sit_stage.sv
module sit_stage #(
  parameter int LEN_W  = 14,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [LEN_W-1:0]  stg_len,
  output logic [1:0]        stg_mode
);
  localparam int HI_W = LEN_W - BYTE_W;

  logic [LEN_W-1:0] len_q, len_d;
  logic [1:0]       mode_q, mode_d;

  always_comb begin
    len_d  = len_q;
    mode_d = mode_q;
    if (lo_we) len_d[BYTE_W-1:0] = wr_data;
    if (hi_we) begin
      len_d[LEN_W-1:BYTE_W] = wr_data[HI_W-1:0];
      mode_d                = wr_data[BYTE_W-1:BYTE_W-2];
    end
  end

  // Staged settings survive reset by intent: no reset term.
  always_ff @(posedge clk) begin
    if (lo_we || hi_we) begin
      len_q  <= len_d;
      mode_q <= mode_d;
    end
  end

  assign stg_len  = len_q;
  assign stg_mode = mode_q;
endmodule

// File: rtl/sit_core.sv
module sit_core
  import sit_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tin_rise,
  input  logic             cmd_we,
  input  logic [1:0]       cmd,
  input  logic [LEN_W-1:0] stg_len,
  input  logic [1:0]       stg_mode,
  output logic [LEN_W-1:0] cnt_o,
  output logic             tmr_out,
  output logic             tc_pulse
);
  localparam int CW = LEN_W + 1;
  localparam logic [CW-1:0] TWO = CW'(2);

  logic             run_q, run_d;
  logic             hi_half_q, hi_half_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [LEN_W-1:0] act_len_q, act_len_d;
  logic [1:0]       act_mode_q, act_mode_d;
  logic             pend_go_q, pend_go_d;
  logic             pend_halt_q, pend_halt_d;
  logic             tc_q, tc_d;
  sit_cmd_e         cmd_e;

  function automatic logic [CW-1:0] first_load(input logic [LEN_W-1:0] len);
    return {1'b0, len} + {{LEN_W{1'b0}}, len[0]};
  endfunction

  function automatic logic [CW-1:0] second_load(input logic [LEN_W-1:0] len);
    return {1'b0, len[LEN_W-1:1], 1'b0};
  endfunction

  assign cmd_e = sit_cmd_e'(cmd);

  always_comb begin
    run_d       = run_q;
    hi_half_d   = hi_half_q;
    cnt_d       = cnt_q;
    act_len_d   = act_len_q;
    act_mode_d  = act_mode_q;
    pend_go_d   = pend_go_q;
    pend_halt_d = pend_halt_q;
    tc_d        = 1'b0;

    if (run_q && tin_rise) begin
      if (cnt_q > TWO) begin
        cnt_d = cnt_q - TWO;
      end else if (hi_half_q) begin
        hi_half_d = 1'b0;
        cnt_d     = second_load(act_len_q);
      end else begin
        tc_d      = 1'b1;
        hi_half_d = 1'b1;
        if (pend_go_q) begin
          act_len_d  = stg_len;
          act_mode_d = stg_mode;
          cnt_d      = first_load(stg_len);
          pend_go_d  = 1'b0;
        end else if (pend_halt_q || !act_mode_q[MODE_REPEAT_BIT]) begin
          run_d       = 1'b0;
          pend_halt_d = 1'b0;
        end else begin
          cnt_d = first_load(act_len_q);
        end
      end
    end

    if (cmd_we) begin
      unique case (cmd_e)
        CMD_HALT: if (run_q) begin
          run_d       = 1'b0;
          hi_half_d   = 1'b1;
          pend_go_d   = 1'b0;
          pend_halt_d = 1'b0;
        end
        CMD_HALT_TC: if (run_d) begin
          pend_halt_d = 1'b1;
          pend_go_d   = 1'b0;
        end
        CMD_GO: if (!run_d) begin
          run_d       = 1'b1;
          hi_half_d   = 1'b1;
          act_len_d   = stg_len;
          act_mode_d  = stg_mode;
          cnt_d       = first_load(stg_len);
          pend_go_d   = 1'b0;
          pend_halt_d = 1'b0;
        end else begin
          pend_go_d   = 1'b1;
          pend_halt_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      hi_half_q   <= 1'b1;
      pend_go_q   <= 1'b0;
      pend_halt_q <= 1'b0;
      tc_q        <= 1'b0;
    end else begin
      run_q       <= run_d;
      hi_half_q   <= hi_half_d;
      pend_go_q   <= pend_go_d;
      pend_halt_q <= pend_halt_d;
      tc_q        <= tc_d;
    end
  end

  // Count and active settings are deliberately left out of reset.
  always_ff @(posedge clk) begin
    cnt_q      <= cnt_d;
    act_len_q  <= act_len_d;
    act_mode_q <= act_mode_d;
  end

  always_comb begin
    if (!run_q)
      tmr_out = 1'b1;
    else if (act_mode_q[MODE_PULSE_BIT])
      tmr_out = hi_half_q || (cnt_q > TWO);
    else
      tmr_out = hi_half_q;
  end

  assign tc_pulse = tc_q;
  assign cnt_o    = cnt_q[LEN_W-1:0];

  assert_tc_one_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);
  assert_tc_after_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> $past(tin_rise));
  assert_idle_no_tc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !tc_pulse);
  assert_halt_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd == 2'b01) |=> !run_q);
  assert_go_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd == 2'b11) |=> run_q);
  assert_cnt_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q[0] == 1'b0));
endmodule

// File: rtl/sq_interval_timer.sv
module sq_interval_timer #(
  parameter int LEN_W       = 14,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_in,
  input  logic              len_lo_we,
  input  logic              len_hi_we,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              cmd_we,
  input  logic [1:0]        cmd,
  output logic              tmr_out,
  output logic              tc_pulse,
  output logic [BYTE_W-1:0] rd_lo,
  output logic [BYTE_W-1:0] rd_hi
);
  logic             tin_rise;
  logic [LEN_W-1:0] stg_len;
  logic [1:0]       stg_mode;
  logic [LEN_W-1:0] cnt;

  sit_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(tmr_in), .rise(tin_rise)
  );

  sit_stage #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_stage (
    .clk(clk), .lo_we(len_lo_we), .hi_we(len_hi_we), .wr_data(wr_data),
    .stg_len(stg_len), .stg_mode(stg_mode)
  );

  sit_core #(.LEN_W(LEN_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tin_rise(tin_rise), .cmd_we(cmd_we), .cmd(cmd),
    .stg_len(stg_len), .stg_mode(stg_mode), .cnt_o(cnt),
    .tmr_out(tmr_out), .tc_pulse(tc_pulse)
  );

  assign rd_lo = cnt[BYTE_W-1:0];
  assign rd_hi = {stg_mode, cnt[LEN_W-1:BYTE_W]};
endmodule

// File: tb/sq_interval_timer_test.sv
module sq_interval_timer_test;
  logic clk = 0;
  logic rst_n = 0;
  logic tmr_in = 0;
  logic len_lo_we = 0, len_hi_we = 0, cmd_we = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] cmd = 0;
  logic tmr_out, tc_pulse;
  logic [7:0] rd_lo, rd_hi;

  int checks = 0;
  int fails = 0;
  int tc_cnt = 0;

  always #5 clk = ~clk;

  sq_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .tmr_in(tmr_in), .len_lo_we(len_lo_we),
    .len_hi_we(len_hi_we), .wr_data(wr_data), .cmd_we(cmd_we), .cmd(cmd),
    .tmr_out(tmr_out), .tc_pulse(tc_pulse), .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  always @(posedge clk) if (rst_n && tc_pulse) tc_cnt <= tc_cnt + 1;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic pulse_in();
    @(negedge clk) tmr_in = 1;
    repeat (4) @(negedge clk);
    tmr_in = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic stage(input int len, input int mode);
    @(negedge clk);
    len_lo_we = 1; wr_data = len[7:0];
    @(negedge clk);
    len_lo_we = 0; len_hi_we = 1; wr_data = {mode[1:0], len[13:8]};
    @(negedge clk);
    len_hi_we = 0;
  endtask

  task automatic command(input logic [1:0] c);
    @(negedge clk);
    cmd_we = 1; cmd = c;
    @(negedge clk);
    cmd_we = 0;
  endtask

  // expected output after edge j (1..L) of a period
  function automatic int exp_out(input int mode, input int len, input int j);
    int h = (len + 1) / 2;
    if (mode[1]) return (j == len - 1) ? 0 : 1;
    return (j < h || j == len) ? 1 : 0;
  endfunction

  task automatic check_period(input string req, input int mode, input int len,
                              input int first, input int last);
    for (int j = first; j <= last; j++) begin
      pulse_in();
      chk(req, tmr_out, exp_out(mode, len, j));
    end
  endtask

  task automatic t_reset();
    int t0;
    chk("R1 out after reset", tmr_out, 1);
    chk("R1 tc after reset", tc_pulse, 0);
    t0 = tc_cnt;
    pulse_in(); pulse_in();
    chk("R1 out idle", tmr_out, 1);
    chk("R1 tc idle", tc_cnt - t0, 0);
  endtask

  task automatic t_single_square();
    int t0 = tc_cnt;
    stage(4, 0);
    command(2'b11);
    check_period("R4 single square L4", 0, 4, 1, 4);
    chk("R6 one tc single", tc_cnt - t0, 1);
    pulse_in(); pulse_in();
    chk("R6 single idle out", tmr_out, 1);
    chk("R6 single no more tc", tc_cnt - t0, 1);
  endtask

  task automatic t_repeat_odd_halt();
    int t0 = tc_cnt;
    stage(5, 1);
    command(2'b11);
    check_period("R4 odd square p1", 1, 5, 1, 5);
    check_period("R4 odd square p2", 1, 5, 1, 5);
    chk("R6 repeat tc count", tc_cnt - t0, 2);
    pulse_in(); pulse_in(); pulse_in();
    chk("R4 odd low half", tmr_out, 0);
    command(2'b01);
    chk("R7 halt out high", tmr_out, 1);
    t0 = tc_cnt;
    repeat (6) pulse_in();
    chk("R7 halt no tc", tc_cnt - t0, 0);
  endtask

  task automatic t_pulse_halt_tc();
    int t0 = tc_cnt;
    stage(3, 3);
    command(2'b11);
    check_period("R5 repeat pulse p1", 3, 3, 1, 3);
    check_period("R5 repeat pulse p2", 3, 3, 1, 3);
    check_period("R5 repeat pulse p3", 3, 3, 1, 1);
    command(2'b10);
    check_period("R8 period finishes", 3, 3, 2, 3);
    chk("R8 tc count", tc_cnt - t0, 3);
    pulse_in(); pulse_in(); pulse_in();
    chk("R8 idle out", tmr_out, 1);
    chk("R8 idle no tc", tc_cnt - t0, 3);
  endtask

  task automatic t_single_pulse();
    int t0 = tc_cnt;
    stage(2, 2);
    command(2'b11);
    check_period("R5 single pulse L2", 2, 2, 1, 2);
    pulse_in();
    chk("R6 single pulse idle", tmr_out, 1);
    chk("R6 single pulse tc", tc_cnt - t0, 1);
  endtask

  task automatic t_readback();
    stage(9, 1);
    command(2'b11);
    pulse_in(); pulse_in();
    chk("R10 rd_lo odd", rd_lo, 6);
    chk("R10 rd_hi odd", rd_hi, 8'h40);
    command(2'b01);
    stage(16'h1234, 0);
    command(2'b11);
    chk("R2 R10 rd_lo load", rd_lo, 8'h34);
    chk("R2 R10 rd_hi load", rd_hi, 8'h12);
    command(2'b01);
  endtask

  task automatic t_deferred();
    stage(4, 1);
    command(2'b11);
    check_period("R9 base", 1, 4, 1, 1);
    stage(6, 1);
    check_period("R9 staged ignored", 1, 4, 2, 4);
    check_period("R9 no start no change", 1, 4, 1, 4);
    check_period("R9 before start", 1, 4, 1, 1);
    command(2'b11);
    check_period("R9 old period kept", 1, 4, 2, 4);
    check_period("R9 new length", 1, 6, 1, 6);
    command(2'b01);
  endtask

  task automatic t_level_hold();
    stage(4, 1);
    command(2'b11);
    @(negedge clk) tmr_in = 1;
    repeat (30) @(negedge clk);
    tmr_in = 0;
    repeat (4) @(negedge clk);
    chk("R11 level counts once", rd_lo, 2);
    chk("R11 still high half", tmr_out, 1);
    command(2'b01);
  endtask

  task automatic t_idle_cmds();
    int t0 = tc_cnt;
    command(2'b10);
    command(2'b01);
    command(2'b00);
    pulse_in(); pulse_in();
    chk("R7 R8 idle cmds no effect", tmr_out, 1);
    chk("R3 idle stays idle", tc_cnt - t0, 0);
    stage(2, 0);
    command(2'b11);
    check_period("R3 start after idle cmds", 0, 2, 1, 2);
    chk("R3 tc after start", tc_cnt - t0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single_square();
    t_repeat_odd_halt();
    t_pulse_halt_tc();
    t_single_pulse();
    t_readback();
    t_deferred();
    t_level_hold();
    t_idle_cmds();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule